// File: doc/BRIEF.md
# UART Interrupt Identification Unit

This block gathers the interrupt conditions of a 16550-style serial port and turns them into one 32-bit identification word for a bus to read, plus a single interrupt request line. Five conventional sources are ranked: receive line error, receive data ready, receive character timeout, transmit holding register empty and modem status change. Only the highest-ranked enabled pending source is encoded. Two extra status bits record that automatic baud detection finished or timed out. These bits stay set until their own clear strobes arrive.

The bus side marks a read of the word with a one-cycle strobe. The sampled pending state is held across the edge that ends the read cycle, so the value the bus saw stays consistent with the block's bookkeeping. An event that arrives during the read cycle is kept aside and merged one cycle later, so the following read reports it. The transmit-empty source is event based: a pulse sets it, and a read that reports it as the winning source clears it.

Top module: `uart_intid`

## Requirements
- R1: After reset the word reads 0x00000001 with the FIFO enable input low, and the request output is 0.
- R2: Bit 0 is active low. It is 0 when any of the five enabled conventional sources is pending and 1 otherwise. When both auto-baud bits are 0, the request output is the inverse of bit 0.
- R3: Bits 3:1 carry the code of the winning source. The codes are line error 011, data ready 010, character timeout 110, transmit empty 001 and modem change 000. The ranking, highest first, is line error, then data ready, then character timeout, then transmit empty, then modem change. With nothing pending the code is 000. The values 100, 101 and 111 never appear.
- R4: A source whose enable bit is 0 has no effect on bits 3:0 or on the request output. The enable vector `src_en` uses bit 4 for line error, bit 3 for data ready, bit 2 for character timeout, bit 1 for transmit empty and bit 0 for modem change.
- R5: A read of the word sees the state registered before the read cycle. A level change or a pulse that arrives in the read cycle is absent from that read and present on a read made two cycles later.
- R6: A read that reports transmit empty (bits 3:0 = 0010) clears that source. A read that reports a higher-ranked source leaves it pending.
- R7: Bits 7:6 both equal the FIFO enable input.
- R8: Bit 8 (auto-baud done) and bit 9 (auto-baud timeout) become 1 in the cycle after their pulse arrives with the matching enable high. A pulse with its enable low is ignored.
- R9: Reading the word does not clear bit 8 or bit 9. Only the matching clear strobe does, and a clear strobe wins over a set pulse in the same cycle.
- R10: Bits 5:4 and 31:10 always read 0.
- R11: The request output is 1 whenever bit 8 or bit 9 is 1, even with no conventional source pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_strobe | input | 1 | One-cycle read of the identification word |
| fifo_en | input | 1 | FIFO enable control bit, mirrored into bits 7:6 |
| src_en | input | 5 | Per-source enables (bit 4 line error … bit 0 modem change) |
| line_err | input | 1 | Receive line error condition (level) |
| rx_ready | input | 1 | Receive data available condition (level) |
| rx_timeout | input | 1 | Receive character timeout condition (level) |
| tx_empty_pulse | input | 1 | Transmit holding register became empty (pulse) |
| modem_chg | input | 1 | Modem status change condition (level) |
| abd_pulse | input | 1 | Auto-baud finished successfully (pulse) |
| abd_en | input | 1 | Enable for the auto-baud done status |
| abd_clr | input | 1 | Clear strobe for the auto-baud done status |
| abt_pulse | input | 1 | Auto-baud timed out (pulse) |
| abt_en | input | 1 | Enable for the auto-baud timeout status |
| abt_clr | input | 1 | Clear strobe for the auto-baud timeout status |
| id_word | output | 32 | Identification word |
| irq | output | 1 | Combined interrupt request |

## Verification
A wrong pending register shows in bits 3:0 one cycle after the condition that should have changed it. The bench samples the word at that point for every ranking pattern in its table. A broken freeze or defer path shows up either as an early appearance in the read's own value or as a lost event on the next read, and both reads are compared. A stuck or wrongly cleared transmit-empty or auto-baud bit appears on the read that follows the clearing or non-clearing action, no more than two cycles later.

// File: rtl/uart_intid_pkg.sv
package uart_intid_pkg;

  localparam int NSRC     = 5;
  localparam int SRC_MSR  = 0;
  localparam int SRC_THRE = 1;
  localparam int SRC_CTI  = 2;
  localparam int SRC_RDA  = 3;
  localparam int SRC_RLS  = 4;
  localparam int IDW      = 3;

  typedef enum logic [IDW-1:0] {
    ID_MSR  = 3'b000,
    ID_THRE = 3'b001,
    ID_RDA  = 3'b010,
    ID_RLS  = 3'b011,
    ID_CTI  = 3'b110
  } id_code_e;

  // Ranking: line error > data ready > char timeout > tx empty > modem.
  function automatic id_code_e pick_id(input logic [NSRC-1:0] p);
    if (p[SRC_RLS])       return ID_RLS;
    else if (p[SRC_RDA])  return ID_RDA;
    else if (p[SRC_CTI])  return ID_CTI;
    else if (p[SRC_THRE]) return ID_THRE;
    else                  return ID_MSR;
  endfunction

endpackage

// File: rtl/uart_intid_srcs.sv
module uart_intid_srcs
  import uart_intid_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd,
  input  logic [NSRC-1:0] lvl_in,
  input  logic            thre_pulse,
  input  logic [NSRC-1:0] src_en,
  input  logic            thre_ack,
  output logic [NSRC-1:0] pend_q
);

  logic            thre_flag_q;
  logic            thre_defer_q;
  logic            thre_flag_d;
  logic [NSRC-1:0] pend_nxt;

  assign thre_flag_d = thre_flag_q | thre_pulse | thre_defer_q;

  always_comb begin
    pend_nxt           = lvl_in & src_en;
    pend_nxt[SRC_THRE] = thre_flag_d & src_en[SRC_THRE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q       <= '0;
      thre_flag_q  <= 1'b0;
      thre_defer_q <= 1'b0;
    end else if (rd) begin
      // Frozen: only the read side effect and the deferral are allowed.
      thre_defer_q <= thre_defer_q | thre_pulse;
      if (thre_ack) begin
        thre_flag_q      <= 1'b0;
        pend_q[SRC_THRE] <= 1'b0;
      end
    end else begin
      pend_q       <= pend_nxt;
      thre_flag_q  <= thre_flag_d;
      thre_defer_q <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_intid_ab.sv
module uart_intid_ab (
  input  logic clk,
  input  logic rst_n,
  input  logic rd,
  input  logic set_pulse,
  input  logic set_en,
  input  logic clr,
  output logic stat_q
);

  logic defer_q;
  logic set_ev;

  assign set_ev = set_pulse & set_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q  <= 1'b0;
      defer_q <= 1'b0;
    end else if (clr) begin
      stat_q  <= 1'b0;
      defer_q <= 1'b0;
    end else if (rd) begin
      defer_q <= defer_q | set_ev;
    end else begin
      stat_q  <= stat_q | defer_q | set_ev;
      defer_q <= 1'b0;
    end
  end

endmodule

// File: rtl/uart_intid_enc.sv
module uart_intid_enc
  import uart_intid_pkg::*;
(
  input  logic [NSRC-1:0] pend,
  output logic [IDW-1:0]  code,
  output logic            none_n
);

  assign code   = pick_id(pend);
  assign none_n = ~|pend;

endmodule

// File: rtl/uart_intid.sv
module uart_intid
  import uart_intid_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_strobe,
  input  logic            fifo_en,
  input  logic [NSRC-1:0] src_en,
  input  logic            line_err,
  input  logic            rx_ready,
  input  logic            rx_timeout,
  input  logic            tx_empty_pulse,
  input  logic            modem_chg,
  input  logic            abd_pulse,
  input  logic            abd_en,
  input  logic            abd_clr,
  input  logic            abt_pulse,
  input  logic            abt_en,
  input  logic            abt_clr,
  output logic [31:0]     id_word,
  output logic            irq
);

  localparam int NAB = 2;

  logic [NSRC-1:0] lvl_w;
  logic [NSRC-1:0] pend_w;
  logic [IDW-1:0]  code_w;
  logic            none_w;
  logic            thre_ack_w;
  logic [NAB-1:0]  ab_set_w;
  logic [NAB-1:0]  ab_en_w;
  logic [NAB-1:0]  ab_clr_w;
  logic [NAB-1:0]  ab_q_w;

  always_comb begin
    lvl_w           = '0;
    lvl_w[SRC_RLS]  = line_err;
    lvl_w[SRC_RDA]  = rx_ready;
    lvl_w[SRC_CTI]  = rx_timeout;
    lvl_w[SRC_MSR]  = modem_chg;
  end

  assign thre_ack_w = rd_strobe & ~none_w & (code_w == ID_THRE);

  uart_intid_srcs u_srcs (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd         (rd_strobe),
    .lvl_in     (lvl_w),
    .thre_pulse (tx_empty_pulse),
    .src_en     (src_en),
    .thre_ack   (thre_ack_w),
    .pend_q     (pend_w)
  );

  uart_intid_enc u_enc (
    .pend   (pend_w),
    .code   (code_w),
    .none_n (none_w)
  );

  assign ab_set_w = {abt_pulse, abd_pulse};
  assign ab_en_w  = {abt_en, abd_en};
  assign ab_clr_w = {abt_clr, abd_clr};

  for (genvar g = 0; g < NAB; g++) begin : g_ab
    uart_intid_ab u_ab (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd        (rd_strobe),
      .set_pulse (ab_set_w[g]),
      .set_en    (ab_en_w[g]),
      .clr       (ab_clr_w[g]),
      .stat_q    (ab_q_w[g])
    );
  end

  assign id_word = {22'd0, ab_q_w, {2{fifo_en}}, 2'b00, code_w, none_w};
  assign irq     = ~none_w | (|ab_q_w);

endmodule

// File: rtl/uart_intid_chk.sv
module uart_intid_chk
  import uart_intid_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            rd_strobe,
  input logic            fifo_en,
  input logic            abd_clr,
  input logic            abt_clr,
  input logic [31:0]     id_word,
  input logic            irq,
  input logic [NSRC-1:0] pend,
  input logic [1:0]      ab_q
);

  localparam logic [NSRC-1:0] LVL_MASK = ~(NSRC'(1) << SRC_THRE);

  assert_resv_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (id_word[31:10] == '0) && (id_word[5:4] == 2'b00));

  assert_code_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (id_word[3:1] != 3'b100) && (id_word[3:1] != 3'b101) && (id_word[3:1] != 3'b111));

  assert_irq_bit0_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_q == 2'b00) |-> (irq == ~id_word[0]));

  assert_irq_ab_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_q != 2'b00) |-> irq);

  assert_freeze_lvl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> ((pend & LVL_MASK) == ($past(pend) & LVL_MASK)));

  assert_freeze_thre_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |=> !(pend[SRC_THRE] && !$past(pend[SRC_THRE])));

  assert_thre_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && id_word[3:0] == 4'b0010) |=> !pend[SRC_THRE]);

  assert_fifo_mirror_R7: assert property (@(posedge clk) disable iff (!rst_n)
    id_word[7:6] == {2{fifo_en}});

  assert_abd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_q[0] && !abd_clr) |=> ab_q[0]);

  assert_abt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_q[1] && !abt_clr) |=> ab_q[1]);

  assert_abd_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abd_clr |=> !ab_q[0]);

  assert_abt_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abt_clr |=> !ab_q[1]);

  assert_ab_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
    id_word[9:8] == ab_q);

endmodule

bind uart_intid uart_intid_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_strobe (rd_strobe),
  .fifo_en   (fifo_en),
  .abd_clr   (abd_clr),
  .abt_clr   (abt_clr),
  .id_word   (id_word),
  .irq       (irq),
  .pend      (pend_w),
  .ab_q      (ab_q_w)
);

// File: tb/uart_intid_bench.sv
`timescale 1ns/1ps
module uart_intid_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_strobe = 1'b0;
  logic        fifo_en = 1'b0;
  logic [4:0]  src_en = '0;
  logic        line_err = 1'b0, rx_ready = 1'b0, rx_timeout = 1'b0;
  logic        tx_empty_pulse = 1'b0, modem_chg = 1'b0;
  logic        abd_pulse = 1'b0, abd_en = 1'b0, abd_clr = 1'b0;
  logic        abt_pulse = 1'b0, abt_en = 1'b0, abt_clr = 1'b0;
  logic [31:0] id_word;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  uart_intid u_uart_intid (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .fifo_en(fifo_en),
    .src_en(src_en), .line_err(line_err), .rx_ready(rx_ready),
    .rx_timeout(rx_timeout), .tx_empty_pulse(tx_empty_pulse),
    .modem_chg(modem_chg), .abd_pulse(abd_pulse), .abd_en(abd_en),
    .abd_clr(abd_clr), .abt_pulse(abt_pulse), .abt_en(abt_en),
    .abt_clr(abt_clr), .id_word(id_word), .irq(irq)
  );

  // {conds rls,rda,cti,msr}[12:9] {src_en}[8:4] {code,bit0}[3:0]
  localparam int NV = 9;
  localparam logic [12:0] VEC [NV] = '{
    {4'b1111, 5'b11111, 4'b0110},
    {4'b0111, 5'b11111, 4'b0100},
    {4'b0011, 5'b11111, 4'b1100},
    {4'b0001, 5'b11111, 4'b0000},
    {4'b0000, 5'b11111, 4'b0001},
    {4'b1111, 5'b01111, 4'b0100},
    {4'b1111, 5'b00001, 4'b0000},
    {4'b1111, 5'b00000, 4'b0001},
    {4'b0010, 5'b11111, 4'b1100}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Read cycle: strobe high for one cycle, word sampled inside it.
  task automatic do_read(output logic [31:0] w);
    rd_strobe = 1'b1;
    #1 w = id_word;
    @(negedge clk);
    rd_strobe = 1'b0;
    chk("R10 reserved", w & 32'hFFFF_FC30, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1 act=timeout exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    repeat (3) @(negedge clk);
    chk("R1 word in reset", id_word, 32'h1);
    rst_n = 1'b1;
    step();
    chk("R1 word after reset", id_word, 32'h1);
    chk("R1 irq after reset", {31'd0, irq}, 32'h0);

    // Ranking and masking table
    for (int i = 0; i < NV; i++) begin
      line_err   = VEC[i][12];
      rx_ready   = VEC[i][11];
      rx_timeout = VEC[i][10];
      modem_chg  = VEC[i][9];
      src_en     = VEC[i][8:4];
      step();
      chk("R3 R4 code", {28'd0, id_word[3:0]}, {28'd0, VEC[i][3:0]});
      chk("R2 irq", {31'd0, irq}, {31'd0, ~VEC[i][0]});
    end
    {line_err, rx_ready, rx_timeout, modem_chg} = '0;
    src_en = 5'b11111;
    step();

    // Transmit empty set and cleared by its own report
    tx_empty_pulse = 1'b1; step(); tx_empty_pulse = 1'b0;
    do_read(w);
    chk("R6 tx empty reported", {28'd0, w[3:0]}, 32'h2);
    step();
    do_read(w);
    chk("R6 cleared by read", {28'd0, w[3:0]}, 32'h1);

    // Not cleared when a higher source is reported
    tx_empty_pulse = 1'b1; line_err = 1'b1; step(); tx_empty_pulse = 1'b0;
    do_read(w);
    chk("R6 line error wins", {28'd0, w[3:0]}, 32'h6);
    line_err = 1'b0; step();
    do_read(w);
    chk("R6 tx empty kept", {28'd0, w[3:0]}, 32'h2);
    step();

    // Pulse arriving in the read cycle is deferred
    tx_empty_pulse = 1'b1;
    do_read(w);
    tx_empty_pulse = 1'b0;
    chk("R5 pulse absent in its read", {28'd0, w[3:0]}, 32'h1);
    step();
    do_read(w);
    chk("R5 pulse present next read", {28'd0, w[3:0]}, 32'h2);
    step();

    // Level arriving in the read cycle
    rx_ready = 1'b1;
    do_read(w);
    chk("R5 level absent in its read", {28'd0, w[3:0]}, 32'h1);
    step();
    do_read(w);
    chk("R5 level present next read", {28'd0, w[3:0]}, 32'h4);
    rx_ready = 1'b0; step();

    // FIFO mirror
    fifo_en = 1'b1; #1;
    chk("R7 mirror high", {30'd0, id_word[7:6]}, 32'h3);
    fifo_en = 1'b0; #1;
    chk("R7 mirror low", {30'd0, id_word[7:6]}, 32'h0);
    step();

    // Auto-baud status
    abt_pulse = 1'b1; step(); abt_pulse = 1'b0;
    chk("R8 disabled timeout ignored", id_word, 32'h1);
    abd_en = 1'b1; abd_pulse = 1'b1; step(); abd_pulse = 1'b0;
    chk("R8 done set", id_word, 32'h101);
    chk("R11 irq from done", {31'd0, irq}, 32'h1);
    do_read(w);
    step();
    chk("R9 read keeps done", id_word, 32'h101);
    abd_clr = 1'b1; step(); abd_clr = 1'b0;
    chk("R9 clear done", id_word, 32'h1);
    chk("R2 irq low", {31'd0, irq}, 32'h0);
    abt_en = 1'b1; abt_pulse = 1'b1; abt_clr = 1'b1; step();
    abt_pulse = 1'b0; abt_clr = 1'b0;
    chk("R9 clear wins over set", id_word, 32'h1);
    abt_pulse = 1'b1;
    do_read(w);
    abt_pulse = 1'b0;
    chk("R5 auto-baud deferred", w, 32'h1);
    step();
    chk("R8 timeout set after defer", id_word, 32'h201);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule